// File: doc/BRIEF.md
# MI Coherent Private Cache Controller

This block is the private, single-level cache controller of one node in a directory-based system that uses only two stable line states. A line is either Modified, so that this node alone holds it and may read or write it, or Invalid. Loads, instruction fetches and stores are treated the same way. A request that finds the line Modified completes locally. Any other request asks the directory for exclusive ownership and waits for the data.

The controller also serves the directory. It evicts lines with a writeback that must be answered by an acknowledge or a refusal. It hands a line directly to another cache when the directory forwards an ownership request. It drops a line when the directory invalidates it. When a writeback is refused, the evicted data is held in a buffer until the forwarded request that caused the refusal arrives. A forward that overtakes the refusal is served from the same buffer.

Storage is a small direct-mapped array of tags, state bits and data, with one line per address. At most one transaction with the directory is outstanding at a time.

Top module: `mi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `core_ready` is high while no directory message and no replacement is presented, and `resp_valid`, `dreq_valid` and `xfer_valid` are low.
- R2: An accepted core request whose address is held Modified gives `resp_valid` exactly one cycle after acceptance, with no directory request. For a load (op 0) or a fetch (op 1), `resp_rdata` is the line data. For a store (op 2), the line takes `core_wdata` and `resp_rdata` returns it.
- R3: An accepted core request whose index holds no Modified line issues `dreq_valid` one cycle later, with kind GETX (0) and the request address, whatever the op. No response is given until data arrives.
- R4: While waiting for ownership, a directory message of kind DATA (0) for the pending address fills the line as Modified and pulses `resp_valid` one cycle later. A load or fetch returns the incoming data. A store returns its own write data, and that data is what the line keeps.
- R5: `repl_valid` on an index that holds a Modified line issues, one cycle later, kind PUTX (1) with that line's address and data, and the line leaves Modified. On an index with no Modified line it has no effect.
- R6: An invalidation (kind 4) for an address held Modified acts exactly like a replacement of that line. An invalidation for an address not held is ignored.
- R7: A forwarded request (kind 1) for an address held Modified drives `xfer_valid` one cycle later, with `xfer_dest` equal to `dresp_src`, the address and the line data. The line leaves Modified.
- R8: An acknowledge (kind 2) ends a writeback. A refusal (kind 3) that comes before any forward keeps the evicted data and the controller busy. The next forward for that address is then served from the held data and ends the transaction.
- R9: A forward that arrives while a writeback awaits its answer is served from the eviction buffer. The later refusal then ends the transaction without a second transfer.
- R10: `core_ready` is low while a transaction is outstanding, while a directory message or replacement is presented, and while the request index holds a Modified line of a different address.
- R11: After ownership of an address passes from one cache to another through a forward, the new owner hits on that address and the old owner misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core request present |
| core_op | input | 2 | 0 load, 1 fetch, 2 store |
| core_addr | input | ADDR_W | Line address of the request |
| core_wdata | input | DATA_W | Store data |
| core_ready | output | 1 | Request accepted this cycle when valid |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Completion data |
| repl_valid | input | 1 | Replacement trigger |
| repl_idx | input | IDX_W | Index to evict |
| dreq_valid | output | 1 | Request to the directory |
| dreq_kind | output | 1 | 0 GETX, 1 PUTX |
| dreq_addr | output | ADDR_W | Request address |
| dreq_data | output | DATA_W | Writeback data |
| dresp_valid | input | 1 | Message from the directory or a peer |
| dresp_kind | input | 3 | 0 DATA, 1 forward, 2 ack, 3 nack, 4 invalidate |
| dresp_addr | input | ADDR_W | Message address |
| dresp_data | input | DATA_W | Fill data |
| dresp_src | input | NODE_W | Requesting node of a forward |
| xfer_valid | output | 1 | Cache-to-cache transfer |
| xfer_dest | output | NODE_W | Receiving node |
| xfer_addr | output | ADDR_W | Transferred address |
| xfer_data | output | DATA_W | Transferred data |

## Verification
The bench builds two controllers with the default parameters: 8-bit line addresses, 16-bit data, a 2-bit index (four lines) and 2-bit node numbers. With only four lines, addresses four apart collide, so the conflict stall and replacements of chosen lines are easy to set up. The two nodes are wired so that each one's transfer output reaches the other as a DATA message. This lets an ownership handoff run through the real forward path, and a probe with hit and miss requests then shows which single node holds the line.

// File: rtl/mi_pkg.sv
package mi_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_FETCH = 2'd1,
    OP_STORE = 2'd2
  } core_op_e;

  typedef enum logic {
    DQ_GETX = 1'b0,
    DQ_PUTX = 1'b1
  } dreq_e;

  typedef enum logic [2:0] {
    DR_DATA = 3'd0,
    DR_FWD  = 3'd1,
    DR_ACK  = 3'd2,
    DR_NACK = 3'd3,
    DR_INV  = 3'd4
  } dresp_e;

  // One outstanding transaction: waiting for data, waiting for the
  // writeback answer, or holding refused data for a forward.
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_IM   = 2'd1,
    TX_MI   = 2'd2,
    TX_MIN  = 2'd3
  } txn_e;

endpackage

// File: rtl/mi_line_array.sv
module mi_line_array #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  parameter int NRD    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx  [NRD],
  output logic              rd_m    [NRD],
  output logic [TAG_W-1:0]  rd_tag  [NRD],
  output logic [DATA_W-1:0] rd_data [NRD],
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx
);
  localparam int LINES = 1 << IDX_W;

  logic              m_q    [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // Modified bits are the only state that needs a reset value.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) m_q[i] <= 1'b0;
    end else begin
      if (clr_en) m_q[clr_idx] <= 1'b0;
      if (wr_en)  m_q[wr_idx]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_m[p]    = m_q[rd_idx[p]];
    assign rd_tag[p]  = tag_q[rd_idx[p]];
    assign rd_data[p] = data_q[rd_idx[p]];
  end

endmodule

// File: rtl/mi_evict_buf.sv
module mi_evict_buf #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              serve_en,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_served
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_addr   <= '0;
      buf_data   <= '0;
      buf_served <= 1'b0;
    end else if (load_en) begin
      buf_addr   <= load_addr;
      buf_data   <= load_data;
      buf_served <= 1'b0;
    end else if (serve_en) begin
      buf_served <= 1'b1;
    end
  end
endmodule

// File: rtl/mi_cache_ctrl.sv
module mi_cache_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  parameter int NODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_valid,
  input  logic [1:0]        core_op,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  input  logic              repl_valid,
  input  logic [IDX_W-1:0]  repl_idx,
  output logic              dreq_valid,
  output logic              dreq_kind,
  output logic [ADDR_W-1:0] dreq_addr,
  output logic [DATA_W-1:0] dreq_data,
  input  logic              dresp_valid,
  input  logic [2:0]        dresp_kind,
  input  logic [ADDR_W-1:0] dresp_addr,
  input  logic [DATA_W-1:0] dresp_data,
  input  logic [NODE_W-1:0] dresp_src,
  output logic              xfer_valid,
  output logic [NODE_W-1:0] xfer_dest,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [DATA_W-1:0] xfer_data
);
  import mi_pkg::*;

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int NRD   = 3;   // ports: 0 core, 1 directory, 2 replacement

  function automatic logic [IDX_W-1:0] line_idx(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] line_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i);
    return {t, i};
  endfunction

  // ---------------- storage ----------------
  logic [IDX_W-1:0]  rd_idx  [NRD];
  logic              rd_m    [NRD];
  logic [TAG_W-1:0]  rd_tag  [NRD];
  logic [DATA_W-1:0] rd_data [NRD];
  logic              wr_en, clr_en;
  logic [IDX_W-1:0]  wr_idx, clr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;

  assign rd_idx[0] = line_idx(core_addr);
  assign rd_idx[1] = line_idx(dresp_addr);
  assign rd_idx[2] = repl_idx;

  mi_line_array #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .NRD(NRD)
  ) u_lines (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_m(rd_m), .rd_tag(rd_tag), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
    .clr_en(clr_en), .clr_idx(clr_idx)
  );

  // ---------------- transaction state ----------------
  txn_e              txn_q;
  logic [ADDR_W-1:0] txn_addr_q;
  core_op_e          pend_op_q;
  logic [DATA_W-1:0] pend_wdata_q;

  logic [ADDR_W-1:0] buf_addr;
  logic [DATA_W-1:0] buf_data;
  logic              buf_served;
  logic [ADDR_W-1:0] ev_addr;
  logic [DATA_W-1:0] ev_data;

  core_op_e cop;
  dresp_e   dk;
  assign cop = core_op_e'(core_op);
  assign dk  = dresp_e'(dresp_kind);

  // ---------------- named events ----------------
  logic txn_idle, txn_busy;
  logic c_conflict, core_take;
  logic ev_hit, ev_miss, ev_fill;
  logic dr_line, buf_match;
  logic ev_fwd_line, ev_inv, ev_repl, ev_evict;
  logic ev_fwd_buf, ev_ack, ev_nack;
  logic [DATA_W-1:0] fill_data;

  assign txn_idle   = (txn_q == TX_IDLE);
  assign txn_busy   = !txn_idle;
  assign c_conflict = rd_m[0] && (rd_tag[0] != line_tag(core_addr));
  assign core_ready = txn_idle && !dresp_valid && !repl_valid && !c_conflict;
  assign core_take  = core_valid && core_ready;
  assign ev_hit     = core_take && rd_m[0];
  assign ev_miss    = core_take && !rd_m[0];

  assign dr_line     = rd_m[1] && (rd_tag[1] == line_tag(dresp_addr));
  assign ev_fwd_line = txn_idle && dresp_valid && (dk == DR_FWD) && dr_line;
  assign ev_inv      = txn_idle && dresp_valid && (dk == DR_INV) && dr_line;
  assign ev_repl     = txn_idle && !dresp_valid && repl_valid && rd_m[2];
  assign ev_evict    = ev_inv || ev_repl;
  assign ev_addr     = ev_repl ? join_addr(rd_tag[2], repl_idx) : dresp_addr;
  assign ev_data     = ev_repl ? rd_data[2] : rd_data[1];

  assign ev_fill = (txn_q == TX_IM) && dresp_valid && (dk == DR_DATA) &&
                   (dresp_addr == txn_addr_q);

  assign buf_match  = dresp_valid && (dresp_addr == buf_addr);
  assign ev_fwd_buf = ((txn_q == TX_MI) || (txn_q == TX_MIN)) && buf_match &&
                      (dk == DR_FWD);
  assign ev_ack     = (txn_q == TX_MI) && buf_match && (dk == DR_ACK);
  assign ev_nack    = (txn_q == TX_MI) && buf_match && (dk == DR_NACK);

  assign fill_data = (pend_op_q == OP_STORE) ? pend_wdata_q : dresp_data;

  // ---------------- array updates ----------------
  assign wr_en   = (ev_hit && (cop == OP_STORE)) || ev_fill;
  assign wr_idx  = ev_fill ? line_idx(txn_addr_q) : line_idx(core_addr);
  assign wr_tag  = ev_fill ? line_tag(txn_addr_q) : line_tag(core_addr);
  assign wr_data = ev_fill ? fill_data : core_wdata;
  assign clr_en  = ev_fwd_line || ev_evict;
  assign clr_idx = ev_repl ? repl_idx : line_idx(dresp_addr);

  mi_evict_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_evict (
    .clk(clk), .rst_n(rst_n),
    .load_en(ev_evict), .load_addr(ev_addr), .load_data(ev_data),
    .serve_en(ev_fwd_buf),
    .buf_addr(buf_addr), .buf_data(buf_data), .buf_served(buf_served)
  );

  // ---------------- transaction FSM ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txn_q        <= TX_IDLE;
      txn_addr_q   <= '0;
      pend_op_q    <= OP_LOAD;
      pend_wdata_q <= '0;
    end else begin
      case (txn_q)
        TX_IDLE: begin
          if (ev_miss) begin
            txn_q        <= TX_IM;
            txn_addr_q   <= core_addr;
            pend_op_q    <= cop;
            pend_wdata_q <= core_wdata;
          end else if (ev_evict) begin
            txn_q <= TX_MI;
          end
        end
        TX_IM:   if (ev_fill) txn_q <= TX_IDLE;
        TX_MI: begin
          if (ev_ack)       txn_q <= TX_IDLE;
          else if (ev_nack) txn_q <= buf_served ? TX_IDLE : TX_MIN;
        end
        TX_MIN:  if (ev_fwd_buf) txn_q <= TX_IDLE;
        default: txn_q <= TX_IDLE;
      endcase
    end
  end

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      dreq_valid <= 1'b0;
      dreq_kind  <= DQ_GETX;
      dreq_addr  <= '0;
      dreq_data  <= '0;
      xfer_valid <= 1'b0;
      xfer_dest  <= '0;
      xfer_addr  <= '0;
      xfer_data  <= '0;
    end else begin
      resp_valid <= ev_hit || ev_fill;
      if (ev_fill)     resp_rdata <= fill_data;
      else if (ev_hit) resp_rdata <= (cop == OP_STORE) ? core_wdata : rd_data[0];

      dreq_valid <= ev_miss || ev_evict;
      if (ev_miss) begin
        dreq_kind <= DQ_GETX;
        dreq_addr <= core_addr;
        dreq_data <= '0;
      end else if (ev_evict) begin
        dreq_kind <= DQ_PUTX;
        dreq_addr <= ev_addr;
        dreq_data <= ev_data;
      end

      xfer_valid <= ev_fwd_line || ev_fwd_buf;
      if (ev_fwd_line || ev_fwd_buf) begin
        xfer_dest <= dresp_src;
        xfer_addr <= dresp_addr;
        xfer_data <= ev_fwd_line ? rd_data[1] : buf_data;
      end
    end
  end

endmodule

// File: rtl/mi_cache_ctrl_chk.sv
module mi_cache_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       core_ready,
  input logic       resp_valid,
  input logic       dreq_valid,
  input logic       dreq_kind,
  input logic       dresp_valid,
  input logic [2:0] dresp_kind,
  input logic       xfer_valid,
  input logic       txn_busy,
  input logic       ev_hit,
  input logic       ev_fill,
  input logic       ev_miss,
  input logic       ev_ack
);
  a_r10_busy_stalls_core: assert property (@(posedge clk) disable iff (!rst_n)
    txn_busy |-> !core_ready);

  a_r2_resp_from_hit_or_fill: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(ev_hit || ev_fill));

  a_r3_getx_from_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq_valid && !dreq_kind) |-> $past(ev_miss));

  a_r5_putx_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq_valid && dreq_kind) |-> $past(!txn_busy));

  a_r7_xfer_after_forward: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> $past(dresp_valid && (dresp_kind == 3'd1)));

  a_r8_ack_frees: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |=> !txn_busy);
endmodule

bind mi_cache_ctrl mi_cache_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_ready(core_ready), .resp_valid(resp_valid),
  .dreq_valid(dreq_valid), .dreq_kind(dreq_kind), .dresp_valid(dresp_valid),
  .dresp_kind(dresp_kind), .xfer_valid(xfer_valid), .txn_busy(txn_busy),
  .ev_hit(ev_hit), .ev_fill(ev_fill), .ev_miss(ev_miss), .ev_ack(ev_ack)
);

// File: tb/mi_cache_ctrl_test.sv
module mi_cache_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench-driven inputs, index 0 = uut (node 0), 1 = peer (node 1)
  logic        cv [2];
  logic [1:0]  cop [2];
  logic [7:0]  ca [2];
  logic [15:0] cw [2];
  logic        rv [2];
  logic [1:0]  ri [2];
  logic        dv [2];
  logic [2:0]  dk [2];
  logic [7:0]  da [2];
  logic [15:0] dd [2];
  logic [1:0]  ds [2];

  logic        rdy [2], rsp_v [2], dq_v [2], dq_k [2], xv [2];
  logic [15:0] rsp_d [2], dq_d [2], xd [2];
  logic [7:0]  dq_a [2], xa [2];
  logic [1:0]  xdst [2];

  // a transfer from the other node arrives as a DATA message
  logic        in_v [2];
  logic [2:0]  in_k [2];
  logic [7:0]  in_a [2];
  logic [15:0] in_d [2];
  logic [1:0]  in_s [2];

  for (genvar n = 0; n < 2; n++) begin : g_route
    logic from_peer;
    assign from_peer = xv[1-n] && (xdst[1-n] == 2'(n));
    assign in_v[n] = from_peer ? 1'b1 : dv[n];
    assign in_k[n] = from_peer ? 3'd0 : dk[n];
    assign in_a[n] = from_peer ? xa[1-n] : da[n];
    assign in_d[n] = from_peer ? xd[1-n] : dd[n];
    assign in_s[n] = from_peer ? 2'(1-n) : ds[n];
  end

  mi_cache_ctrl #(.ADDR_W(8), .DATA_W(16), .IDX_W(2), .NODE_W(2)) uut (
    .clk(clk), .rst_n(rst_n),
    .core_valid(cv[0]), .core_op(cop[0]), .core_addr(ca[0]), .core_wdata(cw[0]),
    .core_ready(rdy[0]), .resp_valid(rsp_v[0]), .resp_rdata(rsp_d[0]),
    .repl_valid(rv[0]), .repl_idx(ri[0]),
    .dreq_valid(dq_v[0]), .dreq_kind(dq_k[0]), .dreq_addr(dq_a[0]), .dreq_data(dq_d[0]),
    .dresp_valid(in_v[0]), .dresp_kind(in_k[0]), .dresp_addr(in_a[0]),
    .dresp_data(in_d[0]), .dresp_src(in_s[0]),
    .xfer_valid(xv[0]), .xfer_dest(xdst[0]), .xfer_addr(xa[0]), .xfer_data(xd[0])
  );

  mi_cache_ctrl #(.ADDR_W(8), .DATA_W(16), .IDX_W(2), .NODE_W(2)) peer (
    .clk(clk), .rst_n(rst_n),
    .core_valid(cv[1]), .core_op(cop[1]), .core_addr(ca[1]), .core_wdata(cw[1]),
    .core_ready(rdy[1]), .resp_valid(rsp_v[1]), .resp_rdata(rsp_d[1]),
    .repl_valid(rv[1]), .repl_idx(ri[1]),
    .dreq_valid(dq_v[1]), .dreq_kind(dq_k[1]), .dreq_addr(dq_a[1]), .dreq_data(dq_d[1]),
    .dresp_valid(in_v[1]), .dresp_kind(in_k[1]), .dresp_addr(in_a[1]),
    .dresp_data(in_d[1]), .dresp_src(in_s[1]),
    .xfer_valid(xv[1]), .xfer_dest(xdst[1]), .xfer_addr(xa[1]), .xfer_data(xd[1])
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Drive a core request at a falling edge, check it is accepted, and return
  // one falling edge later, when the registered outputs show the result.
  task automatic req(input int n, input logic [1:0] op, input logic [7:0] a,
                     input logic [15:0] w, input string tag);
    @(negedge clk);
    cv[n] = 1'b1; cop[n] = op; ca[n] = a; cw[n] = w;
    #1 chk({tag, " accepted"}, 32'(rdy[n]), 1);
    @(negedge clk);
    cv[n] = 1'b0;
    #1;
  endtask

  task automatic dir(input int n, input logic [2:0] k, input logic [7:0] a,
                     input logic [15:0] d, input logic [1:0] s);
    @(negedge clk);
    dv[n] = 1'b1; dk[n] = k; da[n] = a; dd[n] = d; ds[n] = s;
    @(negedge clk);
    dv[n] = 1'b0;
    #1;
  endtask

  task automatic repl(input int n, input logic [1:0] idx);
    @(negedge clk);
    rv[n] = 1'b1; ri[n] = idx;
    @(negedge clk);
    rv[n] = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R1 ready after reset", 32'(rdy[0]), 1);
    chk("R1 resp idle", 32'(rsp_v[0]), 0);
    chk("R1 dreq idle", 32'(dq_v[0]), 0);
    chk("R1 xfer idle", 32'(xv[0]), 0);
    chk("R1 peer ready", 32'(rdy[1]), 1);
  endtask

  task automatic t_load_miss_then_hits;
    req(0, 2'd0, 8'h12, 16'h0, "R3 load miss");
    chk("R3 getx valid", 32'(dq_v[0]), 1);
    chk("R3 getx kind", 32'(dq_k[0]), 0);
    chk("R3 getx addr", 32'(dq_a[0]), 32'h12);
    chk("R3 no early resp", 32'(rsp_v[0]), 0);
    chk("R10 stalled while waiting", 32'(rdy[0]), 0);
    dir(0, 3'd0, 8'h12, 16'hBEEF, 2'd0);
    chk("R4 fill resp", 32'(rsp_v[0]), 1);
    chk("R4 load gets fill data", 32'(rsp_d[0]), 32'hBEEF);
    req(0, 2'd0, 8'h12, 16'h0, "R2 load hit");
    chk("R2 hit resp", 32'(rsp_v[0]), 1);
    chk("R2 hit data", 32'(rsp_d[0]), 32'hBEEF);
    chk("R2 hit no dreq", 32'(dq_v[0]), 0);
    req(0, 2'd2, 8'h12, 16'h1234, "R2 store hit");
    chk("R2 store resp data", 32'(rsp_d[0]), 32'h1234);
    req(0, 2'd1, 8'h12, 16'h0, "R2 fetch hit");
    chk("R2 fetch sees store", 32'(rsp_d[0]), 32'h1234);
  endtask

  task automatic t_store_miss;
    req(0, 2'd2, 8'h25, 16'h5555, "R3 store miss");
    chk("R3 store issues getx", 32'({dq_v[0], dq_k[0]}), 32'b10);
    chk("R3 store getx addr", 32'(dq_a[0]), 32'h25);
    dir(0, 3'd0, 8'h25, 16'h9999, 2'd0);
    chk("R4 store fill resp", 32'(rsp_v[0]), 1);
    chk("R4 store returns own data", 32'(rsp_d[0]), 32'h5555);
    req(0, 2'd0, 8'h25, 16'h0, "R4 readback");
    chk("R4 line kept store data", 32'(rsp_d[0]), 32'h5555);
  endtask

  task automatic t_conflict_stall;
    @(negedge clk);
    cv[0] = 1'b1; cop[0] = 2'd0; ca[0] = 8'h16;
    #1 chk("R10 conflicting index stalls", 32'(rdy[0]), 0);
    cv[0] = 1'b0;
    @(negedge clk);
    rv[0] = 1'b1; ri[0] = 2'd3;
    #1 chk("R10 replacement presented stalls", 32'(rdy[0]), 0);
    rv[0] = 1'b0;
  endtask

  task automatic t_repl_ack;
    repl(0, 2'd2);
    chk("R5 putx valid", 32'({dq_v[0], dq_k[0]}), 32'b11);
    chk("R5 putx addr", 32'(dq_a[0]), 32'h12);
    chk("R5 putx data", 32'(dq_d[0]), 32'h1234);
    chk("R10 busy during writeback", 32'(rdy[0]), 0);
    dir(0, 3'd2, 8'h12, 16'h0, 2'd0);
    chk("R8 ack frees controller", 32'(rdy[0]), 1);
    req(0, 2'd0, 8'h12, 16'h0, "R5 evicted line misses");
    chk("R5 evicted line needs getx", 32'({dq_v[0], dq_k[0]}), 32'b10);
    dir(0, 3'd0, 8'h12, 16'h0042, 2'd0);
    chk("R4 refill data", 32'(rsp_d[0]), 32'h0042);
    repl(0, 2'd3);
    chk("R5 replacement of invalid line ignored", 32'(dq_v[0]), 0);
    chk("R5 still ready", 32'(rdy[0]), 1);
  endtask

  task automatic t_inv_nack_fwd;
    dir(0, 3'd4, 8'h33, 16'h0, 2'd0);
    chk("R6 stray invalidation no dreq", 32'(dq_v[0]), 0);
    chk("R6 stray invalidation leaves ready", 32'(rdy[0]), 1);
    dir(0, 3'd4, 8'h25, 16'h0, 2'd0);
    chk("R6 invalidation writes back", 32'({dq_v[0], dq_k[0]}), 32'b11);
    chk("R6 invalidation addr", 32'(dq_a[0]), 32'h25);
    chk("R6 invalidation data", 32'(dq_d[0]), 32'h5555);
    dir(0, 3'd3, 8'h25, 16'h0, 2'd0);
    chk("R8 nack keeps busy", 32'(rdy[0]), 0);
    chk("R8 nack no transfer", 32'(xv[0]), 0);
    dir(0, 3'd1, 8'h25, 16'h0, 2'd1);
    chk("R8 held data transferred", 32'(xv[0]), 1);
    chk("R8 transfer dest", 32'(xdst[0]), 1);
    chk("R8 transfer data", 32'(xd[0]), 32'h5555);
    chk("R8 done after transfer", 32'(rdy[0]), 1);
  endtask

  task automatic t_fwd_on_m;
    dir(0, 3'd1, 8'h12, 16'h0, 2'd1);
    chk("R7 transfer valid", 32'(xv[0]), 1);
    chk("R7 transfer dest", 32'(xdst[0]), 1);
    chk("R7 transfer addr", 32'(xa[0]), 32'h12);
    chk("R7 transfer data", 32'(xd[0]), 32'h0042);
    req(0, 2'd0, 8'h12, 16'h0, "R7 after forward");
    chk("R7 line gone after forward", 32'({dq_v[0], dq_k[0]}), 32'b10);
    dir(0, 3'd0, 8'h12, 16'h0077, 2'd0);
    chk("R4 refill after forward", 32'(rsp_d[0]), 32'h0077);
  endtask

  task automatic t_fwd_before_nack;
    repl(0, 2'd2);
    chk("R9 putx issued", 32'({dq_v[0], dq_k[0]}), 32'b11);
    dir(0, 3'd1, 8'h12, 16'h0, 2'd1);
    chk("R9 forward served from buffer", 32'(xv[0]), 1);
    chk("R9 buffer data", 32'(xd[0]), 32'h0077);
    chk("R9 still awaiting answer", 32'(rdy[0]), 0);
    dir(0, 3'd3, 8'h12, 16'h0, 2'd0);
    chk("R9 nack gives no second transfer", 32'(xv[0]), 0);
    chk("R9 nack ends transaction", 32'(rdy[0]), 1);
  endtask

  task automatic t_two_nodes;
    req(1, 2'd0, 8'h3A, 16'h0, "R11 peer miss");
    chk("R11 peer getx", 32'({dq_v[1], dq_k[1]}), 32'b10);
    dir(1, 3'd0, 8'h3A, 16'h7777, 2'd0);
    chk("R11 peer owns line", 32'(rsp_d[1]), 32'h7777);
    req(0, 2'd2, 8'h3A, 16'h0ABC, "R11 uut store miss");
    chk("R11 uut getx", 32'({dq_v[0], dq_k[0]}), 32'b10);
    dir(1, 3'd1, 8'h3A, 16'h0, 2'd0);
    chk("R11 peer transfers to uut", 32'({xv[1], xdst[1]}), 32'b100);
    chk("R11 peer transfer data", 32'(xd[1]), 32'h7777);
    @(negedge clk); #1;
    chk("R11 uut completes store", 32'(rsp_v[0]), 1);
    chk("R11 uut store data", 32'(rsp_d[0]), 32'h0ABC);
    req(0, 2'd0, 8'h3A, 16'h0, "R11 uut probe");
    chk("R11 new owner hits", 32'({rsp_v[0], dq_v[0]}), 32'b10);
    chk("R11 new owner data", 32'(rsp_d[0]), 32'h0ABC);
    req(1, 2'd0, 8'h3A, 16'h0, "R11 peer probe");
    chk("R11 old owner misses", 32'({rsp_v[1], dq_v[1], dq_k[1]}), 32'b010);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int n = 0; n < 2; n++) begin
      cv[n] = 0; cop[n] = 0; ca[n] = 0; cw[n] = 0; rv[n] = 0; ri[n] = 0;
      dv[n] = 0; dk[n] = 0; da[n] = 0; dd[n] = 0; ds[n] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_miss_then_hits();
    t_store_miss();
    t_conflict_stall();
    t_repl_ack();
    t_inv_nack_fwd();
    t_fwd_on_m();
    t_fwd_before_nack();
    t_two_nodes();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end
endmodule